// File: doc/BRIEF.md
# Branch Target Unit

This block resolves the two memory-reference branch forms of a 16-bit accumulator machine: the plain jump and the subroutine call. When an instruction word is issued, the unit decodes it and builds a 15-bit effective address. The base is page zero, the current program counter, or accumulator 2 or 3. An 8-bit signed displacement is added to that base. If the instruction asks for indirection, the unit follows the pointer chain through a one-cycle-latency memory read port.

The unit ends with a single-cycle pulse that carries the new program counter. For a call, the same pulse also carries a write of the return address into accumulator 3. A subroutine returns with an ordinary jump: displacement 0 and index 3.

A chain whose every fetched word points onward is cut off after a fixed number of fetches. In that case an error pulse is raised instead of a new program counter.

Top module: `branch_target_unit`

## Requirements
- R1: Only instructions whose five top bits `instr[15:11]` are `00000` (jump) or `00001` (call) are acted on. Any other opcode causes no `pc_valid`, no `mem_rd` and no `ac3_we`, and leaves `busy` low.
- R2: The indirect flag is `instr[10]`, the index selector is `instr[9:8]` and the displacement is `instr[7:0]`.
- R3: With index 0, the effective address is the displacement zero-extended to 15 bits.
- R4: With index 1, the effective address is `pc_in` plus the sign-extended displacement, modulo 2^15.
- R5: With index 2 or 3, the effective address is bits [14:0] of `ac2_in` or `ac3_in` plus the sign-extended displacement, modulo 2^15. Displacement 0 with index 3 therefore returns to the address held in accumulator 3.
- R6: For a direct branch accepted at clock edge k, `pc_valid` is high for exactly the cycle after edge k, with `pc_out` equal to the effective address.
- R7: A call raises `ac3_we` in the same cycle as `pc_valid`, with `ac3_wdata = {1'b0, (pc_in+1) mod 2^15}`. A jump never raises `ac3_we`.
- R8: All operands are taken at the accepting edge. A call indexed through accumulator 3 uses the accumulator value presented with the instruction, not the return address it writes.
- R9: For an indirect branch, `mem_rd` pulses in the cycle after the accepting edge with `mem_addr` equal to the effective address. The read word is taken one cycle after the strobe. If bit 15 of that word is clear, its bits [14:0] become the target, reported as in R6 and R7. If bit 15 is set, a new one-cycle fetch of address bits [14:0] follows in the next cycle.
- R10: A chain makes at most `MAX_LEVELS` fetches. If the last allowed fetch returns a word with bit 15 set, `chain_err` pulses for one cycle, and neither `pc_valid` nor `ac3_we` is raised. A chain that ends on exactly the last allowed fetch completes normally.
- R11: While `busy` is high, `issue` is ignored: the chain in progress ends with its own result and no extra `pc_valid` follows.
- R12: During and after synchronous reset, `pc_valid`, `ac3_we`, `mem_rd`, `chain_err` and `busy` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue | input | 1 | Presents an instruction for decoding this cycle |
| instr | input | 16 | Instruction word |
| pc_in | input | 15 | Program counter of the issued instruction |
| ac2_in | input | 16 | Accumulator 2 value |
| ac3_in | input | 16 | Accumulator 3 value |
| mem_data | input | 16 | Read data, valid the cycle after `mem_rd` |
| pc_valid | output | 1 | New program counter is valid (one-cycle pulse) |
| pc_out | output | 15 | New program counter |
| ac3_we | output | 1 | Write strobe for accumulator 3 |
| ac3_wdata | output | 16 | Return address for accumulator 3 |
| mem_rd | output | 1 | Memory read strobe for an indirection fetch |
| mem_addr | output | 15 | Memory read address |
| busy | output | 1 | An indirect chain is in progress |
| chain_err | output | 1 | Indirection depth limit reached (one-cycle pulse) |

## Verification
A call makes the program-counter load and the accumulator-3 write fall in one cycle. When the call is indexed through accumulator 3, that accumulator is both a source and the destination in that cycle. The bench sweeps every displacement under every index for both opcodes, with `ac3_in` unrelated to the return address. It changes `ac3_in` right after the accepting edge. In the output cycle it compares `pc_out` with the sum formed from the old accumulator and `ac3_wdata` with the incremented program counter, at the same sample.

// File: rtl/btu_pkg.sv
package btu_pkg;
  localparam int OPC_W = 5;
  localparam logic [OPC_W-1:0] OPC_JUMP = 5'b00000;
  localparam logic [OPC_W-1:0] OPC_CALL = 5'b00001;

  typedef enum logic [1:0] {
    IX_ZERO = 2'd0,
    IX_PC   = 2'd1,
    IX_AC2  = 2'd2,
    IX_AC3  = 2'd3
  } btu_index_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RD   = 2'd1,
    ST_USE  = 2'd2
  } btu_state_e;
endpackage

// File: rtl/btu_decode.sv
module btu_decode
  import btu_pkg::*;
#(
  parameter int WORD_W = 16,
  localparam int DISP_W = WORD_W - 8
) (
  input  logic [WORD_W-1:0] instr,
  output logic              is_branch,
  output logic              is_call,
  output logic              indirect,
  output btu_index_e        index,
  output logic [DISP_W-1:0] disp
);
  logic [OPC_W-1:0] opc;

  always_comb begin
    opc       = instr[WORD_W-1 -: OPC_W];
    // R1: both branch opcodes share the four top bits
    is_branch = (opc == OPC_JUMP) || (opc == OPC_CALL);
    is_call   = (opc == OPC_CALL);
    // R2: field positions below the opcode
    indirect  = instr[WORD_W-OPC_W-1];
    index     = btu_index_e'(instr[WORD_W-OPC_W-2 -: 2]);
    disp      = instr[DISP_W-1:0];
  end
endmodule

// File: rtl/btu_ea.sv
module btu_ea
  import btu_pkg::*;
#(
  parameter int WORD_W = 16,
  localparam int AW     = WORD_W - 1,
  localparam int DISP_W = WORD_W - 8
) (
  input  btu_index_e        index,
  input  logic [DISP_W-1:0] disp,
  input  logic [AW-1:0]     pc,
  input  logic [WORD_W-1:0] ac2,
  input  logic [WORD_W-1:0] ac3,
  output logic [AW-1:0]     ea
);
  logic [WORD_W-1:0] sext;
  logic [WORD_W-1:0] base;

  always_comb begin
    sext = {{(WORD_W-DISP_W){disp[DISP_W-1]}}, disp};
    case (index)
      IX_PC:   base = {1'b0, pc};
      IX_AC2:  base = ac2;
      IX_AC3:  base = ac3;
      default: base = '0;
    endcase
    // R3: page zero is unsigned; R4/R5: relative forms wrap at 15 bits
    if (index == IX_ZERO)
      ea = AW'({{(WORD_W-DISP_W){1'b0}}, disp});
    else
      ea = AW'(base + sext);
  end
endmodule

// File: rtl/branch_target_unit.sv
module branch_target_unit
  import btu_pkg::*;
#(
  parameter int WORD_W     = 16,
  parameter int MAX_LEVELS = 8,
  localparam int AW      = WORD_W - 1,
  localparam int DISP_W  = WORD_W - 8,
  localparam int DEPTH_W = $clog2(MAX_LEVELS + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              issue,
  input  logic [WORD_W-1:0] instr,
  input  logic [AW-1:0]     pc_in,
  input  logic [WORD_W-1:0] ac2_in,
  input  logic [WORD_W-1:0] ac3_in,
  input  logic [WORD_W-1:0] mem_data,
  output logic              pc_valid,
  output logic [AW-1:0]     pc_out,
  output logic              ac3_we,
  output logic [WORD_W-1:0] ac3_wdata,
  output logic              mem_rd,
  output logic [AW-1:0]     mem_addr,
  output logic              busy,
  output logic              chain_err
);
  localparam logic [AW-1:0]      PC_ONE    = AW'(1);
  localparam logic [DEPTH_W-1:0] DEPTH_ONE = DEPTH_W'(1);
  localparam logic [DEPTH_W-1:0] DEPTH_MAX = DEPTH_W'(MAX_LEVELS);

  logic              dec_branch, dec_call, dec_ind;
  btu_index_e        dec_index;
  logic [DISP_W-1:0] dec_disp;
  logic [AW-1:0]     ea;
  logic [WORD_W-1:0] ret_addr;
  logic              accept;

  btu_state_e         state_q;
  logic               call_q;
  logic [WORD_W-1:0]  ret_q;
  logic [DEPTH_W-1:0] depth_q;

  btu_decode #(.WORD_W(WORD_W)) u_dec (
    .instr     (instr),
    .is_branch (dec_branch),
    .is_call   (dec_call),
    .indirect  (dec_ind),
    .index     (dec_index),
    .disp      (dec_disp)
  );

  btu_ea #(.WORD_W(WORD_W)) u_ea (
    .index (dec_index),
    .disp  (dec_disp),
    .pc    (pc_in),
    .ac2   (ac2_in),
    .ac3   (ac3_in),
    .ea    (ea)
  );

  assign ret_addr = {1'b0, pc_in + PC_ONE};
  assign accept   = issue && dec_branch && (state_q == ST_IDLE);
  assign busy     = (state_q != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      call_q    <= 1'b0;
      ret_q     <= '0;
      depth_q   <= '0;
      pc_valid  <= 1'b0;
      pc_out    <= '0;
      ac3_we    <= 1'b0;
      ac3_wdata <= '0;
      mem_rd    <= 1'b0;
      mem_addr  <= '0;
      chain_err <= 1'b0;
    end else begin
      pc_valid  <= 1'b0;
      ac3_we    <= 1'b0;
      mem_rd    <= 1'b0;
      chain_err <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (accept) begin
            call_q <= dec_call;
            ret_q  <= ret_addr;
            if (dec_ind) begin
              mem_rd   <= 1'b1;
              mem_addr <= ea;
              depth_q  <= DEPTH_ONE;
              state_q  <= ST_RD;
            end else begin
              pc_valid  <= 1'b1;
              pc_out    <= ea;
              ac3_we    <= dec_call;
              ac3_wdata <= ret_addr;
            end
          end
        end
        ST_RD: state_q <= ST_USE;
        ST_USE: begin
          if (mem_data[WORD_W-1]) begin
            if (depth_q == DEPTH_MAX) begin
              chain_err <= 1'b1;
              state_q   <= ST_IDLE;
            end else begin
              depth_q  <= depth_q + DEPTH_ONE;
              mem_rd   <= 1'b1;
              mem_addr <= mem_data[AW-1:0];
              state_q  <= ST_RD;
            end
          end else begin
            pc_valid  <= 1'b1;
            pc_out    <= mem_data[AW-1:0];
            ac3_we    <= call_q;
            ac3_wdata <= ret_q;
            state_q   <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/btu_checker.sv
module btu_checker #(
  parameter int WORD_W     = 16,
  parameter int MAX_LEVELS = 8,
  localparam int AW    = WORD_W - 1,
  localparam int CNT_W = $clog2(MAX_LEVELS + 2)
) (
  input logic              clk,
  input logic              rst,
  input logic              issue,
  input logic [WORD_W-1:0] instr,
  input logic              pc_valid,
  input logic              ac3_we,
  input logic              mem_rd,
  input logic [AW-1:0]     mem_addr,
  input logic              busy,
  input logic              chain_err
);
  logic [CNT_W-1:0] fetches;
  logic             taken;

  assign taken = issue && !busy && (instr[WORD_W-1 -: 4] == 4'b0000);

  always_ff @(posedge clk) begin
    if (rst || taken) fetches <= '0;
    else if (mem_rd)  fetches <= fetches + CNT_W'(1);
  end

  assert_write_needs_load_R7: assert property (@(posedge clk) disable iff (rst)
    ac3_we |-> pc_valid);

  assert_err_excludes_load_R10: assert property (@(posedge clk) disable iff (rst)
    chain_err |-> !pc_valid && !ac3_we);

  assert_strobe_one_cycle_R9: assert property (@(posedge clk) disable iff (rst)
    mem_rd |=> !mem_rd);

  assert_strobe_addr_held_R9: assert property (@(posedge clk) disable iff (rst)
    mem_rd |=> $stable(mem_addr));

  assert_fetch_only_busy_R11: assert property (@(posedge clk) disable iff (rst)
    mem_rd |-> busy);

  assert_depth_bound_R10: assert property (@(posedge clk) disable iff (rst)
    mem_rd |-> (fetches < CNT_W'(MAX_LEVELS)));
endmodule

bind branch_target_unit btu_checker #(
  .WORD_W     (WORD_W),
  .MAX_LEVELS (MAX_LEVELS)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .issue     (issue),
  .instr     (instr),
  .pc_valid  (pc_valid),
  .ac3_we    (ac3_we),
  .mem_rd    (mem_rd),
  .mem_addr  (mem_addr),
  .busy      (busy),
  .chain_err (chain_err)
);

// File: tb/tb_branch_target_unit.sv
module tb_branch_target_unit;
  localparam int LEVELS = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        issue = 1'b0;
  logic [15:0] instr = '0;
  logic [14:0] pc_in = '0;
  logic [15:0] ac2_in = '0;
  logic [15:0] ac3_in = '0;
  logic [15:0] mem_data = '0;
  logic        pc_valid, ac3_we, mem_rd, busy, chain_err;
  logic [14:0] pc_out, mem_addr;
  logic [15:0] ac3_wdata;

  logic [15:0] mem [0:63];
  int checks = 0;
  int errors = 0;

  branch_target_unit #(.WORD_W(16), .MAX_LEVELS(LEVELS)) dut (
    .clk(clk), .rst(rst), .issue(issue), .instr(instr), .pc_in(pc_in),
    .ac2_in(ac2_in), .ac3_in(ac3_in), .mem_data(mem_data),
    .pc_valid(pc_valid), .pc_out(pc_out), .ac3_we(ac3_we), .ac3_wdata(ac3_wdata),
    .mem_rd(mem_rd), .mem_addr(mem_addr), .busy(busy), .chain_err(chain_err)
  );

  always #4 clk = ~clk;

  always @(posedge clk) if (mem_rd) mem_data <= mem[mem_addr[5:0]];

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [14:0] ea_f(input logic [1:0] idx, input logic [7:0] d,
      input logic [14:0] pc, input logic [15:0] a2, input logic [15:0] a3);
    logic [14:0] sx;
    sx = {{7{d[7]}}, d};
    case (idx)
      2'd0:    return {7'd0, d};
      2'd1:    return pc + sx;
      2'd2:    return a2[14:0] + sx;
      default: return a3[14:0] + sx;
    endcase
  endfunction

  // called at a negedge; returns at the negedge after the accepting edge
  task automatic send(input logic [4:0] op, input bit ind, input logic [1:0] idx,
      input logic [7:0] d, input logic [14:0] pc, input logic [15:0] a2, input logic [15:0] a3);
    instr = {op, ind, idx, d};
    pc_in = pc; ac2_in = a2; ac3_in = a3;
    issue = 1'b1;
    @(negedge clk);
    issue = 1'b0;
    ac2_in = ~a2; ac3_in = ~a3; pc_in = ~pc;   // R8: operands must be held from the edge
  endtask

  task automatic run_chain(output int fetches, output bit got_pc, output bit got_err,
      output logic [14:0] pc_seen, output logic [14:0] first_addr,
      output bit we_seen, output logic [15:0] we_data);
    fetches = 0; got_pc = 0; got_err = 0; we_seen = 0;
    pc_seen = '0; first_addr = '0; we_data = '0;
    for (int i = 0; i < 60; i++) begin
      if (mem_rd) begin
        if (fetches == 0) first_addr = mem_addr;
        fetches++;
      end
      if (pc_valid) begin got_pc = 1; pc_seen = pc_out; we_seen = ac3_we; we_data = ac3_wdata; end
      if (chain_err) got_err = 1;
      if (got_pc || got_err) break;
      @(negedge clk);
    end
  endtask

  initial begin
    #(8 * 150000);
    chk(0, "WDOG", "watchdog expired", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int nf; bit gp, ge, wes; logic [14:0] ps, fa; logic [15:0] wd;
    for (int i = 0; i < 64; i++) mem[i] = 16'(i);
    mem[5] = 16'h0012; mem[6] = 16'h8007; mem[7] = 16'h8005;
    mem[9] = 16'h8009;
    for (int i = 0; i < 7; i++) mem[10+i] = 16'h8000 | 16'(11 + i);
    mem[17] = 16'h0123;
    mem[53] = 16'h0456;

    repeat (3) @(negedge clk);
    chk(!pc_valid && !ac3_we && !mem_rd && !busy && !chain_err, "R12", "reset outputs",
        {pc_valid, ac3_we, mem_rd, busy, chain_err}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!pc_valid && !mem_rd && !busy, "R12", "after reset", {pc_valid, mem_rd, busy}, 0);

    // R3 R4 R5 R6 R7 R8: exhaustive displacement sweep, direct forms
    for (int op = 0; op < 2; op++)
      for (int idx = 0; idx < 4; idx++)
        for (int d = 0; d < 256; d++) begin
          logic [14:0] pc; logic [15:0] a2, a3; logic [14:0] exp;
          pc = 15'(d * 131 + idx * 977 + op * 5 + 16'h7F00);
          a2 = 16'(d * 59 + 16'hC321);
          a3 = 16'(d * 173 + 16'h7F00);
          exp = ea_f(2'(idx), 8'(d), pc, a2, a3);
          send(5'(op), 1'b0, 2'(idx), 8'(d), pc, a2, a3);
          chk(pc_valid === 1'b1, "R6", "pc_valid", pc_valid, 1);
          chk(pc_out === exp, idx == 0 ? "R3" : (idx == 1 ? "R4" : "R5"), "pc_out", pc_out, exp);
          chk(ac3_we === (op == 1), "R7", "ac3_we", ac3_we, op);
          if (op == 1) chk(ac3_wdata === {1'b0, pc + 15'd1}, "R8", "ac3_wdata", ac3_wdata, {1'b0, pc + 15'd1});
          chk(mem_rd === 1'b0, "R2", "direct fetch", mem_rd, 0);
        end
    @(negedge clk);
    chk(pc_valid === 1'b0, "R6", "pulse width", pc_valid, 0);

    // R5: return form, R7: return address wraps
    send(5'd0, 1'b0, 2'd3, 8'd0, 15'd100, 16'd0, 16'h1234);
    chk(pc_out === 15'h1234 && pc_valid, "R5", "return jump", pc_out, 16'h1234);
    send(5'd1, 1'b0, 2'd0, 8'h40, 15'h7FFF, 16'd0, 16'd0);
    chk(ac3_wdata === 16'h0000 && ac3_we, "R7", "wrap return", ac3_wdata, 0);

    // R1: other opcodes ignored, even with the indirect bit set
    for (int op = 2; op < 32; op++) begin
      send(5'(op), 1'b1, 2'(op & 3), 8'd5, 15'd10, 16'd0, 16'd0);
      chk(!pc_valid && !mem_rd && !ac3_we && !busy, "R1", "non-branch opcode",
          {pc_valid, mem_rd, ac3_we, busy}, 0);
    end

    // R9: single-level indirect through a relative address
    send(5'd0, 1'b1, 2'd1, 8'hF5, 15'h0100, 16'd0, 16'd0);
    run_chain(nf, gp, ge, ps, fa, wes, wd);
    chk(fa === 15'h00F5, "R9", "first fetch addr", fa, 16'h00F5);
    chk(gp && ps === 15'h0456 && nf == 1, "R9", "single indirect pc", ps, 16'h0456);

    // R9: three-level chain
    send(5'd0, 1'b1, 2'd0, 8'd6, 15'd0, 16'd0, 16'd0);
    run_chain(nf, gp, ge, ps, fa, wes, wd);
    chk(nf == 3, "R9", "chain fetches", nf, 3);
    chk(gp && ps === 15'h0012 && !wes, "R9", "chain target", ps, 16'h0012);

    // R7 R8: indirect call indexed through ac3, bit 15 of ac3 ignored
    send(5'd1, 1'b1, 2'd3, 8'd1, 15'h7FFF, 16'd0, 16'h8004);
    run_chain(nf, gp, ge, ps, fa, wes, wd);
    chk(fa === 15'd5, "R8", "ea from old ac3", fa, 5);
    chk(gp && wes && wd === 16'h0000 && ps === 15'h0012, "R7", "indirect call write", wd, 0);

    // R10: exactly LEVELS fetches completes
    send(5'd1, 1'b1, 2'd0, 8'd10, 15'd20, 16'd0, 16'd0);
    run_chain(nf, gp, ge, ps, fa, wes, wd);
    chk(nf == LEVELS && gp && !ge, "R10", "max-depth chain ok", nf, LEVELS);
    chk(ps === 15'h0123 && wes && wd === 16'd21, "R10", "max-depth target", ps, 16'h0123);

    // R10: circular chain aborts
    send(5'd1, 1'b1, 2'd0, 8'd9, 15'd20, 16'd0, 16'd0);
    run_chain(nf, gp, ge, ps, fa, wes, wd);
    chk(ge && !gp && nf == LEVELS, "R10", "circular chain error", nf, LEVELS);
    chk(ac3_we === 1'b0, "R10", "no write on error", ac3_we, 0);
    @(negedge clk);
    chk(!busy && !chain_err, "R10", "idle after error", {busy, chain_err}, 0);

    // R11: issue while busy ignored
    send(5'd0, 1'b1, 2'd0, 8'd5, 15'd0, 16'd0, 16'd0);
    chk(busy === 1'b1, "R11", "busy during chain", busy, 1);
    instr = {5'd0, 1'b0, 2'd0, 8'h77}; issue = 1'b1;
    @(negedge clk);
    issue = 1'b0;
    run_chain(nf, gp, ge, ps, fa, wes, wd);
    chk(gp && ps === 15'h0012, "R11", "chain result kept", ps, 16'h0012);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(!pc_valid && !mem_rd, "R11", "no extra result", {pc_valid, mem_rd}, 0);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule